// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block brings a serial display PHY out of power-down. It drives the PHY's three control lines (clock enable, release from shutdown, release from reset) and raises them one at a time, with a timed gap between each. After the last line is raised it waits a settling interval. It then polls the PHY status word once per microsecond until either the PLL-lock bit or the clock-lane stop-state bit is seen. When a bit is seen it reports ready. If neither bit appears within a bounded number of polls it reports a timeout.

A stop command powers the PHY down by clearing all three lines on one edge. All intervals are counted in system-clock cycles through a cycles-per-microsecond parameter, so a simulation can shrink them.

The PHY status word is asynchronous to the system clock. It passes through a synchronizer whose depth is a parameter.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset, and while idle, all three control outputs and both flags (`ready_o`, `timeout_o`) are low.
- R2: On the edge that samples `start_i` high (with `stop_i` low), `phy_clk_en_o` goes high alone. The other two controls and both flags are low.
- R3: `phy_unshut_o` is added exactly GAP_US*CYC_PER_US cycles after the start edge.
- R4: `phy_unrst_o` is added exactly GAP_US*CYC_PER_US cycles after `phy_unshut_o` rose, never before it.
- R5: No status check happens during the SETTLE_US*CYC_PER_US cycles that follow the rise of `phy_unrst_o`. The first check takes place one cycle after that interval ends.
- R6: A check succeeds when bit 0 (PLL lock) or bit 2 (clock-lane stop state) of the synchronized status word is 1. Bit 1 and any other bit have no effect. A successful check raises `ready_o` on that edge.
- R7: Checks repeat every CYC_PER_US cycles. If POLL_MAX checks in a row fail, `timeout_o` rises on the edge of the last check.
- R8: `stop_i` clears all three controls and both flags on the next edge, from any state. It takes priority over a simultaneous `start_i`, and the sequence does not resume afterwards.
- R9: After a timeout, all three controls stay high and `timeout_o` stays set until a start or stop command.
- R10: A `start_i` in any state, including after ready or after a timeout, clears the flags and restarts the sequence from the clock-enable-only step.
- R11: `ready_o` and `timeout_o` are never high together. `ready_o` holds until a start or stop command, even if the status bits later drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin (or restart) the power-up sequence |
| stop_i | input | 1 | Power down: clear all controls and flags |
| phy_status_i | input | STAT_W | Asynchronous PHY status word (bit 0 lock, bit 2 clock-lane stop state) |
| phy_clk_en_o | output | 1 | PHY clock enable |
| phy_unshut_o | output | 1 | PHY release from shutdown (high = powered) |
| phy_unrst_o | output | 1 | PHY release from reset (high = running) |
| ready_o | output | 1 | PHY reported lock or stop state |
| timeout_o | output | 1 | No qualifying status bit within POLL_MAX checks |

## Verification
The assertions take for granted that `start_i` and `stop_i` are single-cycle commands sampled on the rising edge. When both are high together, only the stop is honoured. Nothing is assumed about the timing of `phy_status_i` relative to the clock.

The stimulus drives every command and status change on the falling edge, so each one is stable well before the sampling edge. The stimulus changes the status word only with several cycles of margin before a check, so the synchronizer latency never decides a result. It holds a status pattern long enough for the exact cycle of ready or timeout to follow from the parameters alone.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

   // Status bits that qualify a successful check; these positions are fixed by the PHY.
   localparam int unsigned LOCK_BIT = 0;
   localparam int unsigned STOP_BIT = 2;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_CLKON  = 3'd1,
      SQ_PWRON  = 3'd2,
      SQ_SETTLE = 3'd3,
      SQ_POLL   = 3'd4,
      SQ_READY  = 3'd5,
      SQ_FAIL   = 3'd6
   } seq_state_e;

   typedef struct packed {
      logic clk_en;
      logic unshut;
      logic unrst;
      logic ready;
      logic timeout;
   } seq_out_t;

   function automatic seq_out_t decode_state(seq_state_e s);
      seq_out_t o;
      o.clk_en  = (s != SQ_IDLE);
      o.unshut  = (s != SQ_IDLE) && (s != SQ_CLKON);
      o.unrst   = (s == SQ_SETTLE) || (s == SQ_POLL) || (s == SQ_READY) || (s == SQ_FAIL);
      o.ready   = (s == SQ_READY);
      o.timeout = (s == SQ_FAIL);
      return o;
   endfunction

endpackage

// File: rtl/physeq_status.sv
module physeq_status #(
   parameter int unsigned STAT_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [STAT_W-1:0] HIT_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] status_i,
   output logic              hit_o
);

   logic [STAT_W-1:0] stat_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign stat_q = status_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][STAT_W-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= status_i;
               for (int i = 1; i < int'(SYNC_STAGES); i++) begin
                  pipe_q[i] <= pipe_q[i-1];
               end
            end
         end
         assign stat_q = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   assign hit_o = |(stat_q & HIT_MASK);

endmodule

// File: rtl/physeq_timer.sv
module physeq_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/physeq_poll_ctr.sv
module physeq_poll_ctr #(
   parameter int unsigned POLL_MAX = 100,
   localparam int unsigned PW = (POLL_MAX < 2) ? 1 : $clog2(POLL_MAX)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic miss_i,
   output logic last_o
);

   logic [PW-1:0] miss_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miss_q <= '0;
      end else if (clear_i) begin
         miss_q <= '0;
      end else if (miss_i) begin
         miss_q <= miss_q + 1'b1;
      end
   end

   assign last_o = (32'(miss_q) == POLL_MAX - 1);

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
   import physeq_pkg::*;
#(
   parameter int unsigned CYC_PER_US  = 250,
   parameter int unsigned GAP_US      = 1,
   parameter int unsigned SETTLE_US   = 1000,
   parameter int unsigned POLL_MAX    = 100,
   parameter int unsigned STAT_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [STAT_W-1:0] phy_status_i,
   output logic              phy_clk_en_o,
   output logic              phy_unshut_o,
   output logic              phy_unrst_o,
   output logic              ready_o,
   output logic              timeout_o
);

   localparam int unsigned GAP_CYC    = GAP_US * CYC_PER_US;
   localparam int unsigned SETTLE_CYC = SETTLE_US * CYC_PER_US;
   localparam int unsigned MAX_A      = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
   localparam int unsigned MAX_LOAD   = (MAX_A > CYC_PER_US) ? MAX_A : CYC_PER_US;
   localparam int unsigned CNT_W      = (MAX_LOAD < 2) ? 1 : $clog2(MAX_LOAD);
   localparam logic [STAT_W-1:0] HIT_MASK =
      STAT_W'((1 << LOCK_BIT) | (1 << STOP_BIT));

   generate
      if (CYC_PER_US < 1) begin : g_bad_cyc
         $error("CYC_PER_US must be at least 1");
      end
      if (GAP_US < 1 || SETTLE_US < 1) begin : g_bad_gap
         $error("GAP_US and SETTLE_US must be at least 1");
      end
      if (POLL_MAX < 1) begin : g_bad_poll
         $error("POLL_MAX must be at least 1");
      end
      if (STAT_W <= STOP_BIT) begin : g_bad_stat
         $error("STAT_W must cover the stop-state bit");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             stat_hit;
   logic             poll_miss;
   logic             poll_last;
   seq_out_t         outs;

   physeq_status #(
      .STAT_W     (STAT_W),
      .SYNC_STAGES(SYNC_STAGES),
      .HIT_MASK   (HIT_MASK)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .status_i(phy_status_i),
      .hit_o   (stat_hit)
   );

   physeq_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .load_val_i(tmr_val),
      .zero_o    (tmr_zero)
   );

   physeq_poll_ctr #(
      .POLL_MAX(POLL_MAX)
   ) u_polls (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(state_q != SQ_POLL),
      .miss_i (poll_miss),
      .last_o (poll_last)
   );

   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      poll_miss = 1'b0;
      if (stop_i) begin
         state_d = SQ_IDLE;
      end else if (start_i) begin
         state_d  = SQ_CLKON;
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(GAP_CYC - 1);
      end else begin
         unique case (state_q)
            SQ_CLKON: begin
               if (tmr_zero) begin
                  state_d  = SQ_PWRON;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(GAP_CYC - 1);
               end
            end
            SQ_PWRON: begin
               if (tmr_zero) begin
                  state_d  = SQ_SETTLE;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(SETTLE_CYC - 1);
               end
            end
            SQ_SETTLE: begin
               if (tmr_zero) begin
                  state_d  = SQ_POLL;
                  tmr_load = 1'b1;
                  tmr_val  = '0;
               end
            end
            SQ_POLL: begin
               if (tmr_zero) begin
                  if (stat_hit) begin
                     state_d = SQ_READY;
                  end else if (poll_last) begin
                     state_d = SQ_FAIL;
                  end else begin
                     poll_miss = 1'b1;
                     tmr_load  = 1'b1;
                     tmr_val   = CNT_W'(CYC_PER_US - 1);
                  end
               end
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign outs         = decode_state(state_q);
   assign phy_clk_en_o = outs.clk_en;
   assign phy_unshut_o = outs.unshut;
   assign phy_unrst_o  = outs.unrst;
   assign ready_o      = outs.ready;
   assign timeout_o    = outs.timeout;

endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic stop_i,
   input logic phy_clk_en_o,
   input logic phy_unshut_o,
   input logic phy_unrst_o,
   input logic ready_o,
   input logic timeout_o
);

   // R2
   start_clk_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !stop_i) |=> (phy_clk_en_o && !phy_unshut_o && !phy_unrst_o && !ready_o && !timeout_o));

   // R8
   stop_all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (!phy_clk_en_o && !phy_unshut_o && !phy_unrst_o && !ready_o && !timeout_o));

   // R3
   unshut_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_unshut_o) |-> $past(phy_clk_en_o));

   // R4
   unrst_after_unshut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_unrst_o) |-> $past(phy_unshut_o));

   // R9
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_o && !start_i && !stop_i) |=> (timeout_o && phy_clk_en_o && phy_unshut_o && phy_unrst_o));

   // R11
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready_o && timeout_o));

   // R11
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !start_i && !stop_i) |=> ready_o);

   // R6
   ready_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (phy_clk_en_o && phy_unshut_o && phy_unrst_o));

endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .stop_i      (stop_i),
   .phy_clk_en_o(phy_clk_en_o),
   .phy_unshut_o(phy_unshut_o),
   .phy_unrst_o (phy_unrst_o),
   .ready_o     (ready_o),
   .timeout_o   (timeout_o)
);

// File: tb/phy_pwrup_seq_tb.sv
`timescale 1ns/1ps
module phy_pwrup_seq_tb_top;

   localparam int unsigned C   = 4;
   localparam int unsigned GUS = 1;
   localparam int unsigned SUS = 20;
   localparam int unsigned NP  = 8;
   localparam int G  = GUS * C;               // 4
   localparam int W  = SUS * C;               // 80
   localparam int P1 = 2 * G + W + 1;         // first check edge after start: 89
   localparam int TO = P1 + (NP - 1) * C;     // timeout edge: 117

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [2:0] phy_status_i = 3'b000;
   logic       phy_clk_en_o, phy_unshut_o, phy_unrst_o, ready_o, timeout_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   phy_pwrup_seq #(
      .CYC_PER_US (C),
      .GAP_US     (GUS),
      .SETTLE_US  (SUS),
      .POLL_MAX   (NP),
      .STAT_W     (3),
      .SYNC_STAGES(2)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .stop_i      (stop_i),
      .phy_status_i(phy_status_i),
      .phy_clk_en_o(phy_clk_en_o),
      .phy_unshut_o(phy_unshut_o),
      .phy_unrst_o (phy_unrst_o),
      .ready_o     (ready_o),
      .timeout_o   (timeout_o)
   );

   function automatic logic [4:0] obs();
      return {phy_clk_en_o, phy_unshut_o, phy_unrst_o, ready_o, timeout_o};
   endfunction

   task automatic chk(input string req, input logic [4:0] exp);
      logic [4:0] act;
      act = obs();
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {clk_en,unshut,unrst,ready,timeout} actual %b expected %b at %0t",
                  req, act, exp, $time);
      end
   endtask

   task automatic adv(input int k);
      repeat (k) @(negedge clk);
   endtask

   // Leaves time half a cycle after the edge that sampled start.
   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset", 5'b00000);
      adv(5);
      chk("R1 idle", 5'b00000);
   endtask

   task automatic t_lock_sequence();
      phy_status_i = 3'b001;
      adv(5);
      pulse_start();
      chk("R2 clk_en alone", 5'b10000);
      adv(G - 1);
      chk("R3 before unshut", 5'b10000);
      adv(1);
      chk("R3 unshut added", 5'b11000);
      adv(G - 1);
      chk("R4 before unrst", 5'b11000);
      adv(1);
      chk("R4 unrst added", 5'b11100);
      adv(W);
      chk("R5 no check during settle", 5'b11100);
      adv(1);
      chk("R6 lock bit gives ready", 5'b11110);
      phy_status_i = 3'b000;
      adv(30);
      chk("R11 ready holds", 5'b11110);
      pulse_stop();
      chk("R8 stop from ready", 5'b00000);
   endtask

   task automatic t_stopstate_midpoll();
      phy_status_i = 3'b000;
      adv(5);
      pulse_start();
      adv(P1 + 3 * C);
      chk("R7 still polling", 5'b11100);
      phy_status_i = 3'b100;
      adv(C + 4);
      chk("R6 stop-state bit gives ready", 5'b11110);
      pulse_stop();
      chk("R8 stop", 5'b00000);
   endtask

   task automatic t_timeout();
      phy_status_i = 3'b010;
      adv(5);
      pulse_start();
      adv(TO - 1);
      chk("R6 bit1 ignored before timeout", 5'b11100);
      adv(1);
      chk("R7 timeout on last check", 5'b11101);
      adv(40);
      chk("R9 timeout held, controls high", 5'b11101);
      pulse_start();
      chk("R10 restart from timeout", 5'b10000);
      adv(G);
      chk("R10 restart continues", 5'b11000);
      pulse_stop();
      chk("R8 stop during restart", 5'b00000);
      phy_status_i = 3'b000;
   endtask

   task automatic t_stop_midseq();
      pulse_start();
      adv(G + 1);
      chk("R3 mid sequence", 5'b11000);
      pulse_stop();
      chk("R8 stop mid sequence", 5'b00000);
      adv(3 * G + W);
      chk("R8 sequence not resumed", 5'b00000);
   endtask

   task automatic t_start_stop_same();
      @(negedge clk); start_i = 1'b1; stop_i = 1'b1;
      @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
      chk("R8 stop wins over start", 5'b00000);
      adv(2 * G);
      chk("R8 stays idle", 5'b00000);
   endtask

   task automatic t_fail_then_stop();
      phy_status_i = 3'b000;
      pulse_start();
      adv(TO);
      chk("R7 timeout with no status", 5'b11101);
      pulse_stop();
      chk("R9 stop clears timeout", 5'b00000);
   endtask

   task automatic t_restart_from_ready();
      phy_status_i = 3'b101;
      adv(4);
      pulse_start();
      adv(P1);
      chk("R6 both bits ready", 5'b11110);
      pulse_start();
      chk("R10 restart from ready", 5'b10000);
      pulse_stop();
      chk("R8 final stop", 5'b00000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      adv(3);
      rst_n = 1'b1;
      adv(1);
      t_reset();
      t_lock_sequence();
      t_stopstate_midpoll();
      t_timeout();
      t_stop_midseq();
      t_start_stop_same();
      t_fail_then_stop();
      t_restart_from_ready();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule